// File: doc/BRIEF.md
# LCD Controller Control-Register Reset Unit

This block holds the control state of a dot-matrix LCD controller and applies two reset sources with different reach. An active-low reset pin loads every control register with its default. A reset command, decoded upstream and presented as a strobe with a flag, restores only the addressing, indicator, volume and mode registers. It leaves the display, power, bias and serial-input state as it was.

The block also contains the display timing generator. It produces a line clock pulse, a frame-rate alternation signal, an indicator alternation signal and an active-low blanking output. While the pin reset is active internally, the counters are held cleared and all four timing pins are forced high. After release the generator starts again from line 0. Each register is written through one shared write port, one register per strobe.

Top module: `lcd_ctl_regs`

## Requirements
- R1: While `rst_n` is low, every register takes its default. These are: `disp_on`, `disp_rev`, `seg_rev`, `all_on`, `pwr_save`, `rmw_on`, `stat_on`, `com_rev`, `ratio_mode`, `vol_mode` and `test_mode` at 0; `pwr_ctl`, `stat_mode`, `start_line`, `col_addr`, `page_addr` and `ser_sr` at 0; `vol_lvl` = 6'b100000. `bias_sel` equals parameter `BIAS_DEF`, coded 0 = 1/9, 1 = 1/8, 2 = 1/6.
- R2: A low `rst_n` acts at once, without waiting for a clock edge. Internal reset ends only after two rising clock edges have each sampled `rst_n` high.
- R3: When `cmd_stb` and `cmd_is_reset` are both high at a rising edge, the next rising edge loads the subset with its defaults. The subset is: `rmw_on`, `stat_on`, `stat_mode`, `start_line`, `col_addr`, `page_addr`, `com_rev`, `ratio_mode`, `vol_mode`, `vol_lvl` = 6'b100000 and `test_mode`.
- R4: The reset command leaves `disp_on`, `disp_rev`, `seg_rev`, `pwr_ctl`, `bias_sel`, `all_on`, `pwr_save` and `ser_sr` unchanged.
- R5: A write to a subset register at the edge where the command reset applies is discarded. A write to a register outside the subset at that edge still takes effect.
- R6: `cmd_stb` with `cmd_is_reset` low has no effect on any register.
- R7: With `wr_en` high at a rising edge, the one register selected by `wr_addr` takes the low bits of `wr_data`. The address map is: 0 disp_on, 1 disp_rev, 2 seg_rev, 3 pwr_ctl[2:0], 4 bias_sel[1:0], 5 all_on, 6 pwr_save, 7 rmw_on, 8 {stat_mode[2:1], stat_on[0]}, 9 start_line[5:0], 10 col_addr[7:0], 11 page_addr[3:0], 12 com_rev, 13 ratio_mode, 14 vol_mode, 15 vol_lvl[5:0], 16 test_mode.
- R8: With `ser_shift` high at an edge, `ser_sr` shifts left and takes `ser_bit` into bit 0. Only the pin reset clears it.
- R9: While the internal pin reset is active, `line_clk`, `frame_ac`, `ind_ac` and `blank_n` are all high.
- R10: After release, `line_clk` is high for one cycle every `CL_DIV` cycles, first after the `CL_DIV`-th edge. `frame_ac` starts low and toggles once every `NUM_LINES*CL_DIV` cycles. `ind_ac` equals `frame_ac` when `stat_on` is 1 and is 0 otherwise. `blank_n` equals `disp_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset pin |
| cmd_stb | input | 1 | Command strobe |
| cmd_is_reset | input | 1 | Decoded reset-command flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select |
| wr_data | input | 8 | Write data |
| ser_shift | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial input bit |
| disp_on | output | 1 | Display enable |
| disp_rev | output | 1 | Inverted display |
| seg_rev | output | 1 | Segment direction reversed |
| pwr_ctl | output | 3 | Power control bits |
| bias_sel | output | 2 | Bias selection code |
| all_on | output | 1 | All-pixels-on mode |
| pwr_save | output | 1 | Power-save mode |
| ser_sr | output | 8 | Serial shift register |
| rmw_on | output | 1 | Read-modify-write mode |
| stat_on | output | 1 | Static indicator on |
| stat_mode | output | 2 | Static indicator mode bits |
| start_line | output | LINE_W | Display start line |
| col_addr | output | COL_W | Column address |
| page_addr | output | PAGE_W | Page address |
| com_rev | output | 1 | Common scan direction reversed |
| ratio_mode | output | 1 | Regulator-ratio set mode |
| vol_mode | output | 1 | Volume set mode |
| vol_lvl | output | VOL_W | Electronic volume level |
| test_mode | output | 1 | Test mode |
| line_clk | output | 1 | Line clock pulse |
| frame_ac | output | 1 | Frame alternation signal |
| ind_ac | output | 1 | Indicator alternation signal |
| blank_n | output | 1 | Active-low display blanking |

## Verification
The in-line assertions check on every cycle the properties that can be stated cycle by cycle:
- internal reset leaves only while the pin is high;
- the subset holds its defaults right after a command reset;
- the untouched registers stay stable across one;
- the line counter stays in range;
- the line pulse lasts one cycle;
- the frame signal toggles only at a line wrap.

Only the bench scenarios can show the following:
- the per-register write map;
- a write losing against the reset at the same edge;
- the asynchronous entry into reset between clock edges;
- the parameterised bias default;
- the exact cycle positions of the first line pulse and the first frame toggle.

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs #(
  parameter int BIAS_DEF  = 0,
  parameter int CL_DIV    = 4,
  parameter int NUM_LINES = 65,
  parameter int LINE_W    = 6,
  parameter int COL_W     = 8,
  parameter int PAGE_W    = 4,
  parameter int VOL_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              cmd_is_reset,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ser_shift,
  input  logic              ser_bit,
  output logic              disp_on,
  output logic              disp_rev,
  output logic              seg_rev,
  output logic [2:0]        pwr_ctl,
  output logic [1:0]        bias_sel,
  output logic              all_on,
  output logic              pwr_save,
  output logic [7:0]        ser_sr,
  output logic              rmw_on,
  output logic              stat_on,
  output logic [1:0]        stat_mode,
  output logic [LINE_W-1:0] start_line,
  output logic [COL_W-1:0]  col_addr,
  output logic [PAGE_W-1:0] page_addr,
  output logic              com_rev,
  output logic              ratio_mode,
  output logic              vol_mode,
  output logic [VOL_W-1:0]  vol_lvl,
  output logic              test_mode,
  output logic              line_clk,
  output logic              frame_ac,
  output logic              ind_ac,
  output logic              blank_n
);
  localparam int DIV_W = (CL_DIV > 1) ? $clog2(CL_DIV) : 1;
  localparam int LCNT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CL_DIV - 1);
  localparam logic [LCNT_W-1:0] LINE_LAST = LCNT_W'(NUM_LINES - 1);
  localparam logic [VOL_W-1:0] VOL_DEF = VOL_W'(1) << (VOL_W - 1);
  localparam logic [1:0] BIAS_RST = 2'(BIAS_DEF);

  localparam logic [4:0] A_DISP = 5'd0, A_REV = 5'd1, A_SEG = 5'd2, A_PWR = 5'd3,
                         A_BIAS = 5'd4, A_ALL = 5'd5, A_SAVE = 5'd6, A_RMW = 5'd7,
                         A_STAT = 5'd8, A_LINE = 5'd9, A_COL = 5'd10, A_PAGE = 5'd11,
                         A_COM = 5'd12, A_RATIO = 5'd13, A_VMODE = 5'd14, A_VOL = 5'd15,
                         A_TEST = 5'd16;

  logic [1:0] sync_q;
  logic       rst_sync_n;
  logic       soft_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};

  assign rst_sync_n = sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n) soft_q <= 1'b0;
    else             soft_q <= cmd_stb & cmd_is_reset;

  wire wr_hit = wr_en;

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n) begin
      disp_on  <= 1'b0;
      disp_rev <= 1'b0;
      seg_rev  <= 1'b0;
      pwr_ctl  <= 3'b000;
      bias_sel <= BIAS_RST;
      all_on   <= 1'b0;
      pwr_save <= 1'b0;
    end else if (wr_hit) begin
      case (wr_addr)
        A_DISP: disp_on  <= wr_data[0];
        A_REV:  disp_rev <= wr_data[0];
        A_SEG:  seg_rev  <= wr_data[0];
        A_PWR:  pwr_ctl  <= wr_data[2:0];
        A_BIAS: bias_sel <= wr_data[1:0];
        A_ALL:  all_on   <= wr_data[0];
        A_SAVE: pwr_save <= wr_data[0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n)    ser_sr <= '0;
    else if (ser_shift) ser_sr <= {ser_sr[6:0], ser_bit};

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n || soft_q) begin
      rmw_on     <= 1'b0;
      stat_on    <= 1'b0;
      stat_mode  <= 2'b00;
      start_line <= '0;
      col_addr   <= '0;
      page_addr  <= '0;
      com_rev    <= 1'b0;
      ratio_mode <= 1'b0;
      vol_mode   <= 1'b0;
      vol_lvl    <= VOL_DEF;
      test_mode  <= 1'b0;
    end else if (wr_hit) begin
      case (wr_addr)
        A_RMW:   rmw_on     <= wr_data[0];
        A_STAT:  {stat_mode, stat_on} <= wr_data[2:0];
        A_LINE:  start_line <= wr_data[LINE_W-1:0];
        A_COL:   col_addr   <= wr_data[COL_W-1:0];
        A_PAGE:  page_addr  <= wr_data[PAGE_W-1:0];
        A_COM:   com_rev    <= wr_data[0];
        A_RATIO: ratio_mode <= wr_data[0];
        A_VMODE: vol_mode   <= wr_data[0];
        A_VOL:   vol_lvl    <= wr_data[VOL_W-1:0];
        A_TEST:  test_mode  <= wr_data[0];
        default: ;
      endcase
    end

  logic [DIV_W-1:0]  div_cnt;
  logic [LCNT_W-1:0] line_cnt;
  logic              pulse_q, fr_q;
  wire               div_end = (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n) begin
      div_cnt  <= '0;
      line_cnt <= '0;
      pulse_q  <= 1'b0;
      fr_q     <= 1'b0;
    end else begin
      pulse_q <= div_end;
      div_cnt <= div_end ? '0 : div_cnt + 1'b1;
      if (div_end) begin
        line_cnt <= (line_cnt == LINE_LAST) ? '0 : line_cnt + 1'b1;
        if (line_cnt == LINE_LAST) fr_q <= ~fr_q;
      end
    end

  assign line_clk = !rst_sync_n | pulse_q;
  assign frame_ac = !rst_sync_n | fr_q;
  assign ind_ac   = !rst_sync_n | (stat_on & fr_q);
  assign blank_n  = !rst_sync_n | disp_on;

  assert_sync_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));

  assert_cmd_defaults_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_q |=> (start_line == '0 && col_addr == '0 && page_addr == '0 && vol_lvl == VOL_DEF
                && !rmw_on && !stat_on && stat_mode == 2'b00 && !com_rev && !ratio_mode
                && !vol_mode && !test_mode));

  assert_cmd_keeps_main_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (soft_q && !wr_en && !ser_shift) |=>
      $stable({disp_on, disp_rev, seg_rev, pwr_ctl, bias_sel, all_on, pwr_save, ser_sr}));

  assert_line_range_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_cnt <= LINE_LAST);

  assert_frame_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(fr_q) |-> ($past(line_cnt) == LINE_LAST && $past(div_cnt) == DIV_LAST));

  generate
    if (CL_DIV > 1) begin : g_pulse_chk
      assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
        pulse_q |=> !pulse_q);
    end
  endgenerate
endmodule

// File: tb/lcd_ctl_regs_tb.sv
`timescale 1ns/1ps
module lcd_ctl_regs_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_stb, cmd_is_reset, wr_en, ser_shift, ser_bit;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic disp_on, disp_rev, seg_rev, all_on, pwr_save, rmw_on, stat_on, com_rev;
  logic ratio_mode, vol_mode, test_mode, line_clk, frame_ac, ind_ac, blank_n;
  logic [2:0] pwr_ctl;
  logic [1:0] bias_sel, stat_mode, bias2;
  logic [7:0] ser_sr, col_addr;
  logic [5:0] start_line, vol_lvl;
  logic [3:0] page_addr;

  lcd_ctl_regs u_dut (
    .clk, .rst_n, .cmd_stb, .cmd_is_reset, .wr_en, .wr_addr, .wr_data, .ser_shift, .ser_bit,
    .disp_on, .disp_rev, .seg_rev, .pwr_ctl, .bias_sel, .all_on, .pwr_save, .ser_sr,
    .rmw_on, .stat_on, .stat_mode, .start_line, .col_addr, .page_addr, .com_rev,
    .ratio_mode, .vol_mode, .vol_lvl, .test_mode, .line_clk, .frame_ac, .ind_ac, .blank_n);

  lcd_ctl_regs #(.BIAS_DEF(2)) u_dut2 (
    .clk, .rst_n, .cmd_stb, .cmd_is_reset, .wr_en, .wr_addr, .wr_data, .ser_shift, .ser_bit,
    .disp_on(), .disp_rev(), .seg_rev(), .pwr_ctl(), .bias_sel(bias2), .all_on(), .pwr_save(),
    .ser_sr(), .rmw_on(), .stat_on(), .stat_mode(), .start_line(), .col_addr(), .page_addr(),
    .com_rev(), .ratio_mode(), .vol_mode(), .vol_lvl(), .test_mode(), .line_clk(),
    .frame_ac(), .ind_ac(), .blank_n());

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(logic [4:0] a);
    case (a)
      5'd0: rd = 8'(disp_on);    5'd1: rd = 8'(disp_rev);  5'd2: rd = 8'(seg_rev);
      5'd3: rd = 8'(pwr_ctl);    5'd4: rd = 8'(bias_sel);  5'd5: rd = 8'(all_on);
      5'd6: rd = 8'(pwr_save);   5'd7: rd = 8'(rmw_on);    5'd8: rd = 8'({stat_mode, stat_on});
      5'd9: rd = 8'(start_line); 5'd10: rd = col_addr;     5'd11: rd = 8'(page_addr);
      5'd12: rd = 8'(com_rev);   5'd13: rd = 8'(ratio_mode); 5'd14: rd = 8'(vol_mode);
      5'd15: rd = 8'(vol_lvl);   5'd16: rd = 8'(test_mode);
      default: rd = 8'h00;
    endcase
  endfunction

  // {addr, data, expected readback}
  localparam logic [20:0] VEC [19] = '{
    {5'd0, 8'hFF, 8'h01}, {5'd1, 8'h03, 8'h01}, {5'd2, 8'h01, 8'h01}, {5'd3, 8'hFD, 8'h05},
    {5'd4, 8'h06, 8'h02}, {5'd5, 8'h01, 8'h01}, {5'd6, 8'h01, 8'h01}, {5'd7, 8'h01, 8'h01},
    {5'd8, 8'h05, 8'h05}, {5'd9, 8'hFF, 8'h3F}, {5'd10, 8'hA7, 8'hA7}, {5'd11, 8'h1B, 8'h0B},
    {5'd12, 8'h01, 8'h01}, {5'd13, 8'h01, 8'h01}, {5'd14, 8'h01, 8'h01}, {5'd15, 8'h55, 8'h15},
    {5'd16, 8'h01, 8'h01}, {5'd0, 8'h00, 8'h00}, {5'd3, 8'h02, 8'h02}};

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic defaults_check(string tag);
    chk({tag, " disp_on"}, disp_on, 0);   chk({tag, " disp_rev"}, disp_rev, 0);
    chk({tag, " seg_rev"}, seg_rev, 0);   chk({tag, " pwr_ctl"}, pwr_ctl, 0);
    chk({tag, " bias"}, bias_sel, 0);     chk({tag, " bias2"}, bias2, 2);
    chk({tag, " all_on"}, all_on, 0);     chk({tag, " pwr_save"}, pwr_save, 0);
    chk({tag, " ser_sr"}, ser_sr, 0);     chk({tag, " rmw"}, rmw_on, 0);
    chk({tag, " stat"}, {stat_mode, stat_on}, 0); chk({tag, " line"}, start_line, 0);
    chk({tag, " col"}, col_addr, 0);      chk({tag, " page"}, page_addr, 0);
    chk({tag, " com"}, com_rev, 0);       chk({tag, " ratio"}, ratio_mode, 0);
    chk({tag, " vmode"}, vol_mode, 0);    chk({tag, " vol"}, vol_lvl, 6'h20);
    chk({tag, " test"}, test_mode, 0);
  endtask

  task automatic timing_high(string tag);
    chk({tag, " line_clk"}, line_clk, 1); chk({tag, " frame_ac"}, frame_ac, 1);
    chk({tag, " ind_ac"}, ind_ac, 1);     chk({tag, " blank_n"}, blank_n, 1);
  endtask

  task automatic soft_reset(logic [4:0] a, logic [7:0] d, bit with_wr);
    @(negedge clk); cmd_stb = 1'b1; cmd_is_reset = 1'b1;
    @(negedge clk); cmd_stb = 1'b0; cmd_is_reset = 1'b0;
    if (with_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    #400_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_stb = 0; cmd_is_reset = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ser_shift = 0; ser_bit = 0;
    repeat (3) @(negedge clk);
    defaults_check("R1 in reset");
    timing_high("R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 still held after one edge", line_clk, 1);
    @(negedge clk);
    chk("R2 released after two edges", line_clk, 0);
    defaults_check("R1 after release");

    for (int i = 0; i < 19; i++) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      chk($sformatf("R7 write addr %0d", VEC[i][20:16]), rd(VEC[i][20:16]), VEC[i][7:0]);
    end
    chk("R10 blank_n follows disp_on=0", blank_n, 0);

    foreach (VEC[i]) begin end
    @(negedge clk); ser_shift = 1; ser_bit = 1;
    @(negedge clk); ser_bit = 0;
    @(negedge clk); ser_bit = 1;
    @(negedge clk); ser_bit = 1;
    @(negedge clk); ser_shift = 0;
    chk("R8 shift pattern", ser_sr, 8'h0B);

    soft_reset(5'd0, 8'h00, 1'b0);
    chk("R3 line", start_line, 0); chk("R3 col", col_addr, 0); chk("R3 page", page_addr, 0);
    chk("R3 vol", vol_lvl, 6'h20); chk("R3 rmw", rmw_on, 0); chk("R3 stat", {stat_mode, stat_on}, 0);
    chk("R3 com", com_rev, 0); chk("R3 ratio", ratio_mode, 0); chk("R3 vmode", vol_mode, 0);
    chk("R3 test", test_mode, 0);
    chk("R4 disp_on", disp_on, 0); chk("R4 disp_rev", disp_rev, 1); chk("R4 seg_rev", seg_rev, 1);
    chk("R4 pwr_ctl", pwr_ctl, 2); chk("R4 bias", bias_sel, 2); chk("R4 all_on", all_on, 1);
    chk("R4 pwr_save", pwr_save, 1); chk("R8 ser_sr kept by command", ser_sr, 8'h0B);

    wr(5'd10, 8'h33);
    @(negedge clk); cmd_stb = 1'b1; cmd_is_reset = 1'b0;
    @(negedge clk); cmd_stb = 1'b0;
    @(negedge clk);
    chk("R6 strobe without flag keeps col", col_addr, 8'h33);

    wr(5'd10, 8'h44);
    soft_reset(5'd10, 8'h66, 1'b1);
    chk("R5 subset write loses to reset", col_addr, 8'h00);
    soft_reset(5'd0, 8'h01, 1'b1);
    chk("R5 main write beside reset", disp_on, 1);
    chk("R10 blank_n follows disp_on=1", blank_n, 1);

    wr(5'd8, 8'h01);
    wr(5'd10, 8'h5A);
    @(negedge clk); #1; rst_n = 1'b0; #0.5;
    chk("R2 async entry disp_on", disp_on, 0);
    chk("R2 async entry col", col_addr, 0);
    chk("R2 async entry ser", ser_sr, 0);
    timing_high("R9 async entry");
    repeat (3) @(negedge clk);
    defaults_check("R1 second reset");
    timing_high("R9 held");
    rst_n = 1'b1;
    @(negedge clk);
    timing_high("R9 one edge after release");
    @(negedge clk);
    begin
      int hi = 0;
      for (int k = 1; k <= 262; k++) begin
        @(negedge clk);
        if (k <= 40 && line_clk) hi++;
        if (k == 3) chk("R10 no pulse before edge 4", line_clk, 0);
        if (k == 4) chk("R10 first pulse", line_clk, 1);
        if (k == 5) chk("R10 pulse width", line_clk, 0);
        if (k == 8) chk("R10 second pulse", line_clk, 1);
        if (k == 259) chk("R10 frame low before wrap", frame_ac, 0);
        if (k == 260) begin
          chk("R10 frame toggles at wrap", frame_ac, 1);
          chk("R10 ind_ac low with indicator off", ind_ac, 0);
          chk("R10 blank_n low after reset", blank_n, 0);
        end
      end
      chk("R10 pulse count in 40 cycles", hi, 10);
    end
    wr(5'd8, 8'h01);
    chk("R10 ind_ac follows frame", ind_ac, frame_ac);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule